// File: doc/BRIEF.md
# Compare/Capture Up-Counting Timer

This block is a general-purpose up-counting timer with two channels. Each channel holds one data register. A channel can compare that register against the counter, or it can latch the counter when its input pin changes. The count advance comes from one of several sources: the system clock, two fixed prescaled rates, the underflow pulse of any one of three neighbouring timers, or an edge on an external pin. All pins are synchronised into the system clock domain, so every count advance is a single-cycle enable pulse.

The compare channels drive two waveform outputs, and each output can be inverted. In PWM mode channel 0 sets the period and channel 1 sets the duty on output 0. In one-shot mode both outputs go active when counting starts. Each output returns inactive at its own channel's match. The run ends at channel 0's match. Counting can also be held until a chosen edge arrives on the external pin.

Software controls the block through a simple write/read register port. Reads are combinational from the address. A write takes effect at the next clock edge.

Top module: `cctmr_top`

## Requirements
- R1: After reset the counter, both data registers and both configuration words read zero, both outputs are low and no interrupt pulses. The register addresses are 0 = control, 1 = channel setup, 2 = data register 0, 3 = data register 1 and 4 = counter. A write to address 4 loads the counter.
- R2: Control word layout: bit 0 = run, bits 3:1 = source, bit 4 = external pin counts falling edges (0 = rising), bit 5 = wait for trigger, bit 6 = trigger on falling edge, bits 8:7 = output mode (0 none, 1 PWM, 2 one-shot), bits 10:9 = invert output 1/0. With source 0 the counter advances every cycle. With source 1 it advances once per 8 cycles, and with source 2 once per 32 cycles.
- R3: Sources 3, 4 and 5 advance the counter once per pulse on the underflow input of index 0, 1 and 2. Pulses on the inputs that are not selected have no effect.
- R4: Source 6 advances the counter on the selected edge of the external pin, and only on that edge.
- R5: Advancing from all-ones wraps the counter to zero and gives exactly one overflow interrupt pulse.
- R6: Channel setup layout: bits 1:0 = capture mode for channels 1/0, bits 3:2 = channel 0 edge, bits 5:4 = channel 1 edge (01 rising, 10 falling, 11 both). A selected edge on a capture pin copies the counter into that channel's register. An edge that is not selected leaves the register unchanged.
- R7: Each capture raises one pulse on that channel's interrupt. With both edges selected, every edge gives a pulse.
- R8: A channel in compare mode raises one interrupt pulse when the counter advances while it equals that channel's register.
- R9: In PWM mode the counter clears to zero after advancing at a value equal to register 0. Output 0 is active while the counter is below register 1, and output 1 stays inactive.
- R10: An invert bit flips its output relative to the active level.
- R11: In one-shot mode both outputs go active on the first counting cycle. Output n stays active for as many counts as register n holds. At channel 0's match the counter clears and the run bit clears by itself.
- R12: With wait-for-trigger set, the counter holds while running until the selected edge appears on the external pin. After that edge it counts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| uf_in | input | 3 | Underflow pulses from neighbouring timers |
| ext_in | input | 1 | External count / trigger pin |
| cap_in | input | 2 | Capture pins, one per channel |
| wave_out | output | 2 | Waveform outputs |
| ovf_irq | output | 1 | Overflow interrupt pulse |
| ch_irq | output | 2 | Per-channel match/capture interrupt pulses |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, prescale divides of 8 and 32, and three underflow inputs. These values keep the slowest prescaled rate measurable within a few thousand cycles. Loading the counter near all-ones makes the wrap reachable in a handful of cycles. Capture values are checked exactly by holding the counter stopped at a loaded value while the pins toggle. PWM and one-shot waveforms are checked by counting active output cycles over fixed windows.

// File: rtl/cctmr_pkg.sv
package cctmr_pkg;

   typedef enum logic [1:0] {
      OM_NONE    = 2'd0,
      OM_PWM     = 2'd1,
      OM_ONESHOT = 2'd2,
      OM_RSVD    = 2'd3
   } omode_e;

   typedef struct packed {
      logic [4:0] rsvd;
      logic [1:0] inv;
      omode_e     omode;
      logic       trig_fall;
      logic       trig_en;
      logic       ext_fall;
      logic [2:0] src;
      logic       run;
   } ctrl_t;

   typedef struct packed {
      logic [9:0]      rsvd;
      logic [1:0][1:0] edge_sel;
      logic [1:0]      capm;
   } chcfg_t;

   localparam int A_CTRL  = 0;
   localparam int A_CHCFG = 1;
   localparam int A_REG0  = 2;
   localparam int A_CNT   = 4;

   localparam int SRC_SYS  = 0;
   localparam int SRC_DIVA = 1;
   localparam int SRC_DIVB = 2;
   localparam int SRC_UF0  = 3;

endpackage

// File: rtl/cctmr_sync_edge.sv
module cctmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   initial begin : chk_stages
      if (STAGES < 2) $error("cctmr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         last <= 1'b0;
      end else begin
         sh   <= {sh[STAGES-2:0], pin};
         last <= sh[STAGES-1];
      end
   end

   assign rise = sh[STAGES-1] & ~last;
   assign fall = ~sh[STAGES-1] & last;

endmodule

// File: rtl/cctmr_tick_sel.sv
module cctmr_tick_sel #(
   parameter int DIV_A = 8,
   parameter int DIV_B = 32,
   parameter int N_UF  = 3,
   parameter int SRC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src,
   input  logic [N_UF-1:0]  uf_pulse,
   input  logic             ext_rise,
   input  logic             ext_fall,
   input  logic             ext_fall_sel,
   output logic             tick
);
   import cctmr_pkg::*;

   localparam int SRC_EXT = SRC_UF0 + N_UF;

   initial begin : chk_params
      if (DIV_A < 2 || DIV_B < 2) $error("cctmr_tick_sel: divides must be at least 2");
      if (SRC_EXT >= (1 << SRC_W)) $error("cctmr_tick_sel: SRC_W too narrow for N_UF");
   end

   logic [1:0] pre_tick;

   for (genvar d = 0; d < 2; d++) begin : g_pre
      localparam int DIV = (d == 0) ? DIV_A : DIV_B;
      localparam int PW  = $clog2(DIV);
      logic [PW-1:0] pc;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    pc <= '0;
         else if (pc == PW'(DIV - 1))   pc <= '0;
         else                           pc <= pc + 1'b1;
      end

      assign pre_tick[d] = (pc == PW'(DIV - 1));

      // R2
      pre_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pre_tick[d] |=> !pre_tick[d]);
   end

   always_comb begin
      tick = 1'b0;
      if (src == SRC_W'(SRC_SYS))       tick = 1'b1;
      else if (src == SRC_W'(SRC_DIVA)) tick = pre_tick[0];
      else if (src == SRC_W'(SRC_DIVB)) tick = pre_tick[1];
      else if (src == SRC_W'(SRC_EXT))  tick = ext_fall_sel ? ext_fall : ext_rise;
      for (int k = 0; k < N_UF; k++) begin
         if (src == SRC_W'(SRC_UF0 + k)) tick = uf_pulse[k];
      end
   end

endmodule

// File: rtl/cctmr_channel.sv
module cctmr_channel #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wr_data,
   input  logic         cap_mode,
   input  logic [1:0]   cap_edge,
   input  logic         pin_rise,
   input  logic         pin_fall,
   input  logic [W-1:0] cnt,
   input  logic         adv,
   output logic [W-1:0] val,
   output logic         match,
   output logic         irq
);
   logic cap_evt;

   assign cap_evt = cap_mode & ((cap_edge[0] & pin_rise) | (cap_edge[1] & pin_fall));
   assign match   = ~cap_mode & adv & (cnt == val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val <= '0;
         irq <= 1'b0;
      end else begin
         if (wr)           val <= wr_data;
         else if (cap_evt) val <= cnt;
         irq <= cap_evt | match;
      end
   end

   // R6
   cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && !wr) |=> (val == $past(cnt)));

   // R7
   cap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_mode && !cap_evt && !match) |=> !irq);

endmodule

// File: rtl/cctmr_top.sv
module cctmr_top #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3,
   parameter int DIV_A  = 8,
   parameter int DIV_B  = 32,
   parameter int N_UF   = 3,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  rd_data,
   input  logic [N_UF-1:0]   uf_in,
   input  logic              ext_in,
   input  logic [1:0]        cap_in,
   output logic [1:0]        wave_out,
   output logic              ovf_irq,
   output logic [1:0]        ch_irq
);
   import cctmr_pkg::*;

   localparam int N_CH   = 2;
   localparam int CFG_W  = $bits(ctrl_t);
   localparam int SRC_W  = 3;

   initial begin : chk_params
      if (CNT_W < CFG_W) $error("cctmr_top: CNT_W must hold a control word");
      if ((1 << ADDR_W) <= A_CNT) $error("cctmr_top: ADDR_W too narrow");
   end

   ctrl_t            ctrl;
   chcfg_t           chc;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cval [N_CH];
   logic [N_CH-1:0]  match, cap_rise, cap_fall, os_act, act;
   logic             ext_rise, ext_fall, tick, trig_seen, go, go_q, start, adv;
   logic             wr_ctrl, wr_chc, wr_cnt, os_done, pwm_wrap;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
   assign wr_chc  = wr_en && (addr == ADDR_W'(A_CHCFG));
   assign wr_cnt  = wr_en && (addr == ADDR_W'(A_CNT));

   cctmr_sync_edge #(.STAGES(SYNC_N)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_in), .rise(ext_rise), .fall(ext_fall));

   cctmr_tick_sel #(.DIV_A(DIV_A), .DIV_B(DIV_B), .N_UF(N_UF), .SRC_W(SRC_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .src(ctrl.src), .uf_pulse(uf_in),
      .ext_rise(ext_rise), .ext_fall(ext_fall), .ext_fall_sel(ctrl.ext_fall), .tick(tick));

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      cctmr_sync_edge #(.STAGES(SYNC_N)) u_sync (
         .clk(clk), .rst_n(rst_n), .pin(cap_in[c]), .rise(cap_rise[c]), .fall(cap_fall[c]));

      cctmr_channel #(.W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .wr(wr_en && (addr == ADDR_W'(A_REG0 + c))), .wr_data(wr_data),
         .cap_mode(chc.capm[c]), .cap_edge(chc.edge_sel[c]),
         .pin_rise(cap_rise[c]), .pin_fall(cap_fall[c]),
         .cnt(cnt), .adv(adv), .val(cval[c]), .match(match[c]), .irq(ch_irq[c]));
   end

   // start gating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          trig_seen <= 1'b0;
      else if (!ctrl.run)  trig_seen <= 1'b0;
      else if (ctrl.trig_fall ? ext_fall : ext_rise) trig_seen <= 1'b1;
   end

   assign go       = ctrl.run & (~ctrl.trig_en | trig_seen);
   assign adv      = go & tick;
   assign start    = go & ~go_q;
   assign os_done  = (ctrl.omode == OM_ONESHOT) & match[0];
   assign pwm_wrap = (ctrl.omode == OM_PWM) & adv & (cnt == cval[0]);

   // counter and control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ctrl    <= '0;
         chc     <= '0;
         go_q    <= 1'b0;
         ovf_irq <= 1'b0;
      end else begin
         go_q    <= go;
         ovf_irq <= adv & (cnt == '1);
         if (wr_cnt)                     cnt <= wr_data;
         else if (pwm_wrap || os_done)   cnt <= '0;
         else if (adv)                   cnt <= cnt + 1'b1;
         if (wr_ctrl)                    ctrl <= ctrl_t'(wr_data[CFG_W-1:0]);
         else if (os_done)               ctrl.run <= 1'b0;
         if (wr_chc)                     chc <= chcfg_t'(wr_data[CFG_W-1:0]);
      end
   end

   // one-shot output state
   for (genvar c = 0; c < N_CH; c++) begin : g_os
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                          os_act[c] <= 1'b0;
         else if (!ctrl.run || ctrl.omode != OM_ONESHOT)      os_act[c] <= 1'b0;
         else if (start)                                      os_act[c] <= 1'b1;
         else if (match[c] || os_done)                        os_act[c] <= 1'b0;
      end
   end

   always_comb begin
      act = '0;
      case (ctrl.omode)
         OM_PWM:     act[0] = ctrl.run & (cnt < cval[1]);
         OM_ONESHOT: act    = os_act & ~chc.capm;
         default:    act    = '0;
      endcase
   end

   assign wave_out = act ^ ctrl.inv;

   always_comb begin
      rd_data = '0;
      case (addr)
         ADDR_W'(A_CTRL):     rd_data = CNT_W'(ctrl);
         ADDR_W'(A_CHCFG):    rd_data = CNT_W'(chc);
         ADDR_W'(A_REG0):     rd_data = cval[0];
         ADDR_W'(A_REG0 + 1): rd_data = cval[1];
         ADDR_W'(A_CNT):      rd_data = cnt;
         default:             rd_data = '0;
      endcase
   end

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !wr_cnt) |=> $stable(cnt));

   // R5
   wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cnt == '1 && !wr_cnt) |=> (cnt == '0 && ovf_irq));

   // R9
   pwm_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_wrap && !wr_cnt) |=> (cnt == '0));

   // R11
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (os_done && !wr_ctrl) |=> !ctrl.run);

   // R12
   trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.trig_en && !trig_seen && !wr_cnt) |=> $stable(cnt));

endmodule

// File: tb/cctmr_top_test.sv
module cctmr_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [2:0]  uf_in = '0;
   logic        ext_in = 1'b0;
   logic [1:0]  cap_in = '0;
   logic [1:0]  wave_out;
   logic        ovf_irq;
   logic [1:0]  ch_irq;

   int vectors = 0, miscompares = 0;
   int n_ovf = 0, n_i0 = 0, n_i1 = 0, n_w0 = 0, n_w1 = 0;
   bit mon_en = 1'b0, finished = 1'b0;

   always #10 clk = ~clk;

   cctmr_top uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .uf_in(uf_in), .ext_in(ext_in), .cap_in(cap_in),
      .wave_out(wave_out), .ovf_irq(ovf_irq), .ch_irq(ch_irq));

   always @(negedge clk) begin
      if (ovf_irq)   n_ovf++;
      if (ch_irq[0]) n_i0++;
      if (ch_irq[1]) n_i1++;
      if (mon_en && wave_out[0]) n_w0++;
      if (mon_en && wave_out[1]) n_w1++;
   end

   function automatic logic [15:0] ctl(input bit run, input int src, input bit extf,
                                       input bit trg, input bit trgf, input int om,
                                       input int inv);
      return {5'b0, 2'(inv), 2'(om), trgf, trg, extf, 3'(src), run};
   endfunction

   task automatic chk(input string tag, input int act, input int lo, input int hi);
      vectors++;
      if (act < lo || act > hi) begin
         miscompares++;
         if (lo == hi) $display("FAIL %s: actual %0h expected %0h", tag, act, lo);
         else          $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr = 3'(a); wr_data = 16'(d); wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      addr = 3'(a);
      #1 d = int'(rd_data);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      int v;
      for (int a = 0; a < 5; a++) begin
         rd(a, v);
         chk($sformatf("R1 reg %0d after reset", a), v, 0, 0);
      end
      chk("R1 outputs after reset", int'(wave_out), 0, 0);
      chk("R1 irqs after reset", int'({ovf_irq, ch_irq}), 0, 0);
   endtask

   task automatic rate(input int src, input int cyc, input int lo, input int hi);
      int v;
      wr(4, 0);
      wr(0, ctl(1, src, 0, 0, 0, 0, 0));
      idle(cyc);
      wr(0, 0);
      rd(4, v);
      chk($sformatf("R2 count for source %0d", src), v, lo, hi);
   endtask

   task automatic t_rates;
      rate(0, 100, 99, 102);
      rate(1, 800, 99, 101);
      rate(2, 3200, 99, 101);
   endtask

   task automatic t_uf;
      int v;
      wr(4, 0);
      wr(0, ctl(1, 4, 0, 0, 0, 0, 0));
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         uf_in = (i < 3) ? 3'b011 : 3'b010;
         @(negedge clk);
         uf_in = 3'b000;
         idle(2);
      end
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); uf_in = 3'b101;
         @(negedge clk); uf_in = 3'b000;
      end
      wr(0, 0);
      rd(4, v);
      chk("R3 underflow 1 selected, others ignored", v, 7, 7);
   endtask

   task automatic ext_run(input bit extf, input int exp);
      int v;
      ext_in = 1'b0;
      idle(6);
      wr(4, 0);
      wr(0, ctl(1, 6, extf, 0, 0, 0, 0));
      ext_in = 1'b1; idle(6);
      ext_in = 1'b0; idle(6);
      ext_in = 1'b1; idle(6);
      wr(0, 0);
      rd(4, v);
      chk(extf ? "R4 external falling edges" : "R4 external rising edges", v, exp, exp);
      ext_in = 1'b0;
      idle(6);
   endtask

   task automatic t_ext;
      ext_run(1'b0, 2);
      ext_run(1'b1, 1);
   endtask

   task automatic t_ovf;
      int v, base;
      wr(4, 16'hFFFD);
      base = n_ovf;
      wr(0, ctl(1, 0, 0, 0, 0, 0, 0));
      idle(10);
      wr(0, 0);
      idle(2);
      rd(4, v);
      chk("R5 overflow pulse count", n_ovf - base, 1, 1);
      chk("R5 counter wrapped to small value", v, 8, 14);
   endtask

   task automatic t_capture;
      int v, b0, b1;
      wr(0, 0);
      wr(1, 16'h0037);
      wr(4, 16'h1111);
      b0 = n_i0; b1 = n_i1;
      cap_in = 2'b11;
      idle(6);
      rd(2, v); chk("R6 ch0 rising capture", v, 16'h1111, 16'h1111);
      rd(3, v); chk("R6 ch1 both-edge capture on rise", v, 16'h1111, 16'h1111);
      wr(4, 16'h2222);
      cap_in = 2'b00;
      idle(6);
      rd(2, v); chk("R6 ch0 falling edge ignored", v, 16'h1111, 16'h1111);
      rd(3, v); chk("R6 ch1 both-edge capture on fall", v, 16'h2222, 16'h2222);
      chk("R7 ch0 capture irq count", n_i0 - b0, 1, 1);
      chk("R7 ch1 capture irq count (both edges)", n_i1 - b1, 2, 2);
      wr(1, 0);
   endtask

   task automatic t_match;
      int b0, b1;
      wr(2, 5);
      wr(3, 9);
      wr(4, 0);
      b0 = n_i0; b1 = n_i1;
      wr(0, ctl(1, 0, 0, 0, 0, 0, 0));
      idle(14);
      wr(0, 0);
      idle(2);
      chk("R8 ch0 compare match irq", n_i0 - b0, 1, 1);
      chk("R8 ch1 compare match irq", n_i1 - b1, 1, 1);
   endtask

   task automatic t_pwm;
      int w0, w1, v;
      wr(2, 4);
      wr(3, 2);
      wr(4, 0);
      wr(0, ctl(1, 0, 0, 0, 0, 1, 0));
      idle(7);
      w0 = n_w0; w1 = n_w1; mon_en = 1'b1;
      idle(50);
      mon_en = 1'b0;
      chk("R9 PWM output 0 active cycles per 50", n_w0 - w0, 20, 20);
      chk("R9 PWM output 1 stays inactive", n_w1 - w1, 0, 0);
      rd(4, v);
      chk("R9 PWM counter below period", v, 0, 4);
      wr(0, ctl(1, 0, 0, 0, 0, 1, 1));
      idle(5);
      w0 = n_w0; mon_en = 1'b1;
      idle(50);
      mon_en = 1'b0;
      chk("R10 inverted PWM output 0 high cycles per 50", n_w0 - w0, 30, 30);
      wr(0, 0);
      chk("R10 output 0 idle level without inversion", int'(wave_out[0]), 0, 0);
   endtask

   task automatic t_oneshot;
      int w0, w1, b0, b1, v;
      wr(2, 20);
      wr(3, 8);
      wr(4, 0);
      w0 = n_w0; w1 = n_w1; b0 = n_i0; b1 = n_i1;
      mon_en = 1'b1;
      wr(0, ctl(1, 0, 0, 0, 0, 2, 0));
      idle(40);
      mon_en = 1'b0;
      chk("R11 one-shot output 0 active cycles", n_w0 - w0, 20, 20);
      chk("R11 one-shot output 1 active cycles", n_w1 - w1, 8, 8);
      chk("R11 one-shot match irqs", (n_i0 - b0) * 16 + (n_i1 - b1), 17, 17);
      rd(0, v);
      chk("R11 run bit cleared after one-shot", v & 1, 0, 0);
      rd(4, v);
      chk("R11 counter cleared after one-shot", v, 0, 0);
      wr(0, 0);
   endtask

   task automatic t_trig;
      int v;
      ext_in = 1'b0;
      idle(4);
      wr(4, 0);
      wr(0, ctl(1, 0, 0, 1, 0, 0, 0));
      idle(20);
      rd(4, v);
      chk("R12 counter held before trigger", v, 0, 0);
      ext_in = 1'b1;
      idle(10);
      rd(4, v);
      chk("R12 counting after trigger edge", v, 5, 10);
      wr(0, 0);
      ext_in = 1'b0;
      idle(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_rates();
      t_uf();
      t_ext();
      t_ovf();
      t_capture();
      t_match();
      t_pwm();
      t_oneshot();
      t_trig();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule